// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a small microcontroller core is in debug mode and drives the core-side consequences of that mode. There are two ways in. The first is the level of an active-low debug pin as the system reset ends. The second is a pulse from the core reporting that it has executed a breakpoint instruction. The only way out is an explicit exit command from the debug interface, or a reset taken while the pin is high.

While debug mode is active, the block does three things. It stalls instruction fetch, except in cycles where the debugger injects an instruction. It refreshes the watchdog continuously while the watchdog is enabled and the clock is not stopped. It raises a one-cycle request that pulls the core out of HALT each time the mode is entered.

The block also protects the baud-rate detector. A pin that is still held low after reset must not be mistaken for a sync character. After a reset-time entry, the detector stays gated until the debug pin first rises. The pin passes through a two-flop synchronizer before any of this logic looks at it.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: Reset is synchronous and active high. At the last clock edge with reset high, the synchronized pin level is evaluated. Low means `in_debug` is 1 in the first cycle after reset; high means it is 0. The raw pin must be stable for at least two clocks before that edge.
- R2: While not in debug mode, a `brk_exec` sampled high at a clock edge sets `in_debug` from that edge on.
- R3: `fetch_stall` is 1 exactly when `in_debug` is 1 and `inject_req` is 0. Outside debug mode it is 0.
- R4: `halt_exit` is high for exactly one cycle per entry. For a breakpoint entry, that is the cycle after the entering edge. For a reset-time entry, it is the first cycle after reset.
- R5: `wdt_refresh` is 1 in every cycle where `in_debug`, `wdt_enable` and not `stop_mode` all hold, and 0 otherwise.
- R6: In debug mode, an `exit_cmd` sampled high clears `in_debug` and `fetch_stall` from the next cycle. It wins over a simultaneous `brk_exec`. Outside debug mode, `exit_cmd` has no effect.
- R7: A `brk_exec` received while already in debug mode is ignored. `in_debug` stays 1 and no `halt_exit` pulse occurs.
- R8: After a reset-time entry, `baud_enable` is 0 for as long as the pin stays low, including a hold longer than 5000 cycles. It becomes 1 on the third clock edge after the raw pin rises (two synchronizer stages plus edge detection). Once open, it stays 1 even if the pin falls again.
- R9: A reset taken with the pin high clears debug mode, even if debug mode was active before, and leaves `baud_enable` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| dbg_pin_n | input | 1 | Raw debug pin, active low, asynchronous |
| brk_exec | input | 1 | One-cycle pulse: breakpoint instruction executed |
| exit_cmd | input | 1 | One-cycle pulse: leave debug mode |
| inject_req | input | 1 | Debugger is injecting an instruction this cycle |
| wdt_enable | input | 1 | Watchdog timer enabled |
| stop_mode | input | 1 | Clock stopped (STOP mode) |
| in_debug | output | 1 | Debug mode active |
| fetch_stall | output | 1 | Stop instruction fetch |
| halt_exit | output | 1 | One-cycle request to leave HALT |
| wdt_refresh | output | 1 | Watchdog refresh strobe |
| baud_enable | output | 1 | Baud-rate detector may observe the pin |

## Verification
Mode changes caused by `brk_exec` or `exit_cmd` are due one edge after the edge that samples them. The bench therefore drives each input on a falling edge and compares against its model on the following falling edge. `fetch_stall` and `wdt_refresh` follow the registered mode and the live inputs within the same cycle, so they are compared in that same half-period. The reset-time state and its `halt_exit` pulse are checked in the half-cycle right after reset is released. The baud gate is checked after two edges, when it must still be closed, and after three edges, when it must be open, following the raw pin rise.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_DEBUG = 1'b1
    } mode_e;

    typedef struct packed {
        logic fetch_stall;
        logic halt_exit;
        logic wdt_refresh;
    } core_ctl_t;

    function automatic mode_e mode_after_reset(logic pin_low);
        return pin_low ? MODE_DEBUG : MODE_RUN;
    endfunction

    function automatic mode_e next_mode(mode_e cur, logic brk, logic leave);
        mode_e nxt;
        nxt = cur;
        if (cur == MODE_DEBUG) begin
            if (leave) nxt = MODE_RUN;
        end else if (brk) begin
            nxt = MODE_DEBUG;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= d_async;
            end else begin : g_next
                always_ff @(posedge clk) chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_low,
    input  logic      brk_exec,
    input  logic      exit_cmd,
    input  logic      inject_req,
    input  logic      wdt_enable,
    input  logic      stop_mode,
    output mode_e     mode,
    output core_ctl_t ctl
);
    mode_e mode_q;
    mode_e mode_d;
    logic  wake_q;

    always_comb begin
        mode_d = next_mode(mode_q, brk_exec, exit_cmd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_after_reset(pin_low);
            wake_q <= pin_low;
        end else begin
            mode_q <= mode_d;
            wake_q <= (mode_q == MODE_RUN) && (mode_d == MODE_DEBUG);
        end
    end

    always_comb begin
        ctl.fetch_stall = (mode_q == MODE_DEBUG) && !inject_req;
        ctl.halt_exit   = wake_q;
        ctl.wdt_refresh = (mode_q == MODE_DEBUG) && wdt_enable && !stop_mode;
    end

    assign mode = mode_q;
endmodule

// File: rtl/dbg_baud_gate.sv
module dbg_baud_gate (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_sync,
    output logic baud_enable
);
    logic closed_q;
    logic pin_prev_q;
    logic pin_rise;

    assign pin_rise = pin_n_sync && !pin_prev_q;

    always_ff @(posedge clk) begin
        pin_prev_q <= pin_n_sync;
        if (rst) begin
            closed_q <= !pin_n_sync;
        end else if (closed_q && pin_rise) begin
            closed_q <= 1'b0;
        end
    end

    assign baud_enable = !closed_q;
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
    import dbg_mode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dbg_pin_n,
    input  logic brk_exec,
    input  logic exit_cmd,
    input  logic inject_req,
    input  logic wdt_enable,
    input  logic stop_mode,
    output logic in_debug,
    output logic fetch_stall,
    output logic halt_exit,
    output logic wdt_refresh,
    output logic baud_enable
);
    logic      pin_n_s;
    mode_e     mode;
    core_ctl_t ctl;

    dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .d_async (dbg_pin_n),
        .q_sync  (pin_n_s)
    );

    dbg_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pin_low    (!pin_n_s),
        .brk_exec   (brk_exec),
        .exit_cmd   (exit_cmd),
        .inject_req (inject_req),
        .wdt_enable (wdt_enable),
        .stop_mode  (stop_mode),
        .mode       (mode),
        .ctl        (ctl)
    );

    dbg_baud_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .pin_n_sync  (pin_n_s),
        .baud_enable (baud_enable)
    );

    assign in_debug    = (mode == MODE_DEBUG);
    assign fetch_stall = ctl.fetch_stall;
    assign halt_exit   = ctl.halt_exit;
    assign wdt_refresh = ctl.wdt_refresh;
endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic brk_exec,
    input logic exit_cmd,
    input logic wdt_enable,
    input logic stop_mode,
    input logic in_debug,
    input logic fetch_stall,
    input logic halt_exit,
    input logic wdt_refresh,
    input logic baud_enable
);
    AST_BRK_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (!in_debug && brk_exec) |=> (in_debug && halt_exit)); // R2

    AST_EXIT_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (in_debug && exit_cmd) |=> (!in_debug && !fetch_stall)); // R6

    AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!in_debug && exit_cmd && !brk_exec) |=> !in_debug); // R6

    AST_BRK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (in_debug && brk_exec && !exit_cmd) |=> (in_debug && !halt_exit)); // R7

    AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        halt_exit |=> !halt_exit); // R4

    AST_NO_STALL_RUN: assert property (@(posedge clk) disable iff (rst)
        !in_debug |-> (!fetch_stall && !halt_exit)); // R3

    AST_WDT_ONLY_DEBUG: assert property (@(posedge clk) disable iff (rst)
        (!in_debug || stop_mode || !wdt_enable) |-> !wdt_refresh); // R5

    AST_GATE_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
        baud_enable |=> baud_enable); // R8
endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .brk_exec    (brk_exec),
    .exit_cmd    (exit_cmd),
    .wdt_enable  (wdt_enable),
    .stop_mode   (stop_mode),
    .in_debug    (in_debug),
    .fetch_stall (fetch_stall),
    .halt_exit   (halt_exit),
    .wdt_refresh (wdt_refresh),
    .baud_enable (baud_enable)
);

// File: tb/tb_dbg_mode_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_mode_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dbg_pin_n = 1'b1;
    logic brk_exec = 1'b0, exit_cmd = 1'b0, inject_req = 1'b0;
    logic wdt_enable = 1'b0, stop_mode = 1'b0;
    logic in_debug, fetch_stall, halt_exit, wdt_refresh, baud_enable;

    int tests = 0;
    int fails = 0;
    logic m_dbg, m_halt;

    always #4 clk = ~clk;

    dbg_mode_ctrl dut (
        .clk(clk), .rst(rst), .dbg_pin_n(dbg_pin_n), .brk_exec(brk_exec),
        .exit_cmd(exit_cmd), .inject_req(inject_req), .wdt_enable(wdt_enable),
        .stop_mode(stop_mode), .in_debug(in_debug), .fetch_stall(fetch_stall),
        .halt_exit(halt_exit), .wdt_refresh(wdt_refresh), .baud_enable(baud_enable)
    );

    function automatic logic exp_stall(logic dbg, logic inj);
        return dbg && !inj;
    endfunction

    function automatic logic exp_wdt(logic dbg, logic en, logic stp);
        return dbg && en && !stp;
    endfunction

    task automatic check(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " R1/R2/R6 in_debug"}, in_debug, m_dbg);
        check({tag, " R4 halt_exit"}, halt_exit, m_halt);
        check({tag, " R3 fetch_stall"}, fetch_stall, exp_stall(m_dbg, inject_req));
        check({tag, " R5 wdt_refresh"}, wdt_refresh, exp_wdt(m_dbg, wdt_enable, stop_mode));
    endtask

    // at negedge: drive, take one posedge, update model, check at next negedge
    task automatic cyc(logic b, logic e, logic inj, logic we, logic st, string tag);
        brk_exec = b; exit_cmd = e; inject_req = inj; wdt_enable = we; stop_mode = st;
        @(posedge clk);
        m_halt = !m_dbg && b;
        m_dbg  = m_dbg ? !e : b;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset(logic pin);
        brk_exec = 0; exit_cmd = 0; inject_req = 0;
        dbg_pin_n = pin;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        m_dbg = !pin;
        m_halt = !pin;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic gate_ok;
        @(negedge clk);

        // R1 / R9: reset with pin high
        do_reset(1'b1);
        check_all("R1 pin-high reset");
        check("R9 gate open after pin-high reset", baud_enable, 1'b1);

        // R2, R4: breakpoint entry
        cyc(0, 0, 0, 1, 0, "idle");
        cyc(0, 1, 0, 1, 0, "R6 exit in run ignored");
        cyc(1, 0, 0, 1, 0, "R2 brk entry");
        cyc(0, 0, 0, 1, 0, "R4 pulse ends");
        cyc(1, 0, 0, 1, 0, "R7 brk in debug ignored");
        cyc(0, 0, 1, 1, 1, "R3 inject / R5 stop");
        cyc(1, 1, 0, 1, 0, "R6 exit wins over brk");
        cyc(0, 0, 0, 1, 0, "R6 after exit");

        // R9: reset while in debug with pin high
        cyc(1, 0, 0, 0, 0, "R2 re-entry");
        do_reset(1'b1);
        check_all("R9 reset clears debug");

        // R1 / R8: reset-time entry with long low hold
        do_reset(1'b0);
        check_all("R1 pin-low reset");
        check("R8 gate closed after pin-low reset", baud_enable, 1'b0);
        gate_ok = 1'b1;
        for (int i = 0; i < 5200; i++) begin
            @(negedge clk);
            if (baud_enable !== 1'b0) gate_ok = 1'b0;
        end
        m_halt = 1'b0;
        check("R8 gate closed during 5200-cycle hold", gate_ok, 1'b1);
        check("R1 still in debug during hold", in_debug, 1'b1);
        dbg_pin_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 gate closed two edges after rise", baud_enable, 1'b0);
        @(negedge clk);
        check("R8 gate open three edges after rise", baud_enable, 1'b1);
        dbg_pin_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 gate stays open after pin falls", baud_enable, 1'b1);
        check_all("R8 mode unaffected by gate");
        dbg_pin_n = 1'b1;
        repeat (3) @(negedge clk);

        // random phase
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            logic b, e;
            b = ($urandom_range(0, 7) == 0);
            e = ($urandom_range(0, 7) == 0);
            cyc(b, e, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 5) == 0, "rand R2/R6/R7");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule